// File: doc/BRIEF.md
# Gated Edge Counter with Serial Readout

This core measures frequency or period. A wide counter adds one for each rising edge of a chosen source signal while a gate input is held low. The source is either an internal reference clock or an external signal, picked by a select pin. A host runs each measurement in four steps:

- It pulses clear.
- It opens the gate for a known time, or for a number of periods of the unknown signal.
- It closes the gate again.
- It reads the result.

To read the result, the host holds load low and gives one rising edge on the shift clock. This copies the count into a shift register. The host then raises load and clocks the value out one bit per shift clock edge, most significant bit first.

Every pin is sampled by one fast core clock. Each pin passes through a two-stage synchronizer. An edge register follows, and it turns transitions into single-cycle events. Counting, capture and shifting all act on those events. A gate change therefore always lands on a whole count step. The control pins are active low and rest high.

Top module: `gcnt_top`

## Requirements
- R1: While gate_n is low, each rising edge of the selected source adds exactly one to the counter. The counter is CNT_W bits wide, 32 by default.
- R2: While gate_n is high, the counter keeps its value no matter what the sources do.
- R3: While clr_n is low, the counter reads zero and the overflow flag is cleared. Clear wins over counting.
- R4: src_sel = 1 counts ref_sig and src_sel = 0 counts ext_sig. Edges on the source that is not selected have no effect.
- R5: A rising edge of sclk_n while load_n is low copies the whole counter into the shift register. ser_out then shows the counter's MSB.
- R6: A rising edge of sclk_n while load_n is high shifts the register one place toward ser_out and fills a zero at the LSB. After CNT_W shifts, ser_out stays 0.
- R7: The counter wraps from all ones to zero. On that step ovf is set, and it stays set until a clear.
- R8: After reset, the counter is zero, the shift register is zero, and ser_out and ovf are 0.
- R9: A change on any input pin takes effect on the third rising clk edge after it. That is two synchronizer stages plus one edge-detect register. Each source level must last at least one clk period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low counter clear |
| gate_n | input | 1 | Active-low count enable |
| load_n | input | 1 | Active-low capture select for the shift clock |
| sclk_n | input | 1 | Shift clock, idle high, acts on its rising edge |
| src_sel | input | 1 | Source select: 1 = ref_sig, 0 = ext_sig |
| ext_sig | input | 1 | External signal to count |
| ref_sig | input | 1 | Internal reference clock to count |
| ser_out | output | 1 | Serial result, MSB first |
| ovf | output | 1 | Sticky counter wrap flag |

## Verification
The checker watches the counter and the shift register on every cycle. It checks that the counter moves by at most one per cycle and not at all while the gate is closed. It also checks that clear forces zero, that overflow is sticky, and that a capture copies the count exactly. A shift must move the bits by one place and the register must hold when no shift clock edge arrives.

Some behaviour only the bench scenarios can show. These are the choice between the two sources, the value read back over the serial handshake, the wrap of a narrow instance, and the three-edge latency. For these the bench compares the outputs with a pin-level model on every cycle.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    // Raw pin levels as seen by the synchronizer.
    typedef struct packed {
        logic clr_n;
        logic gate_n;
        logic load_n;
        logic sclk_n;
        logic sel;
        logic ext;
        logic refs;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    // Controls rest high, the sources and the select rest low.
    localparam pins_t PINS_IDLE = '{clr_n: 1'b1, gate_n: 1'b1, load_n: 1'b1,
                                    sclk_n: 1'b1, sel: 1'b0, ext: 1'b0, refs: 1'b0};

    // Decoded controls and events in the core clock domain.
    typedef struct packed {
        logic clr;
        logic open;
        logic sel_ref;
        logic load;
        logic tick_ref;
        logic tick_ext;
        logic sclk_rise;
    } ctl_t;

    function automatic ctl_t decode_pins(input pins_t lvl, input pins_t prev);
        ctl_t c;
        c.clr       = ~lvl.clr_n;
        c.open      = ~lvl.gate_n;
        c.sel_ref   = lvl.sel;
        c.load      = ~lvl.load_n;
        c.tick_ref  = lvl.refs & ~prev.refs;
        c.tick_ext  = lvl.ext & ~prev.ext;
        c.sclk_rise = lvl.sclk_n & ~prev.sclk_n;
        return c;
    endfunction

endpackage

// File: rtl/gcnt_sync.sv
module gcnt_sync
    import gcnt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pin,
    output pins_t lvl,
    output pins_t prev
);
    localparam int DEPTH = STAGES + 1;

    // Stages 0..STAGES-1 synchronize. The last stage holds the previous level.
    pins_t pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= PINS_IDLE;
        end else begin
            pipe[0] <= pin;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign prev = pipe[STAGES];
endmodule

// File: rtl/gcnt_ctr.sv
module gcnt_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            if (cnt == TOP) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/gcnt_shr.sv
module gcnt_shr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] sh,
    output logic         sout
);
    always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (cap)   sh <= din;
        else if (shift) sh <= {sh[W-2:0], 1'b0};
    end

    assign sout = sh[W-1];
endmodule

// File: rtl/gcnt_top.sv
module gcnt_top
    import gcnt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic gate_n,
    input  logic load_n,
    input  logic sclk_n,
    input  logic src_sel,
    input  logic ext_sig,
    input  logic ref_sig,
    output logic ser_out,
    output logic ovf
);
    pins_t pin_in, pin_lvl, pin_prev;
    ctl_t  ctl;

    logic             clr_act, gate_open, tick, inc, sclk_rise, load_act, cap, shift;
    logic [CNT_W-1:0] cnt, sh;

    assign pin_in = {clr_n, gate_n, load_n, sclk_n, src_sel, ext_sig, ref_sig};

    gcnt_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (pin_in),
        .lvl (pin_lvl),
        .prev(pin_prev)
    );

    always_comb ctl = decode_pins(pin_lvl, pin_prev);

    assign clr_act   = ctl.clr;
    assign gate_open = ctl.open;
    assign tick      = ctl.sel_ref ? ctl.tick_ref : ctl.tick_ext;
    assign inc       = tick & gate_open;
    assign sclk_rise = ctl.sclk_rise;
    assign load_act  = ctl.load;
    assign cap       = sclk_rise & load_act;
    assign shift     = sclk_rise & ~load_act;

    gcnt_ctr #(.W(CNT_W)) u_ctr (
        .clk(clk),
        .rst(rst),
        .clr(clr_act),
        .inc(inc),
        .cnt(cnt),
        .ovf(ovf)
    );

    gcnt_shr #(.W(CNT_W)) u_shr (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .shift(shift),
        .din  (cnt),
        .sh   (sh),
        .sout (ser_out)
    );
endmodule

// File: rtl/gcnt_chk.sv
module gcnt_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_act,
    input logic         gate_open,
    input logic         cap,
    input logic         shift,
    input logic [W-1:0] cnt,
    input logic [W-1:0] sh,
    input logic         ovf
);
    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (cnt == '0) && !ovf);

    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && !clr_act) |=> $stable(cnt));

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_act |=> (cnt == $past(cnt)) || (cnt == W'($past(cnt) + 1'b1)));

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> sh == $past(cnt));

    // R6
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> (sh[0] == 1'b0) && (sh[W-1:1] == $past(sh[W-2:0])));

    // R6
    sh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap && !shift) |=> $stable(sh));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_act) |=> ovf);
endmodule

bind gcnt_top gcnt_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_act  (clr_act),
    .gate_open(gate_open),
    .cap      (cap),
    .shift    (shift),
    .cnt      (cnt),
    .sh       (sh),
    .ovf      (ovf)
);

// File: tb/gcnt_top_tb.sv
module gcnt_top_tb;
    import gcnt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1, gate_n = 1'b1, load_n = 1'b1, sclk_n = 1'b1;
    logic src_sel = 1'b0, ext_sig = 1'b0, ref_sig = 1'b0;
    logic so32, so8, ov32, ov8;
    logic ref_run = 1'b0, ext_run = 1'b0;
    logic started = 1'b0, done = 1'b0;
    int   nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    gcnt_top u_dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .gate_n(gate_n), .load_n(load_n),
        .sclk_n(sclk_n), .src_sel(src_sel), .ext_sig(ext_sig), .ref_sig(ref_sig),
        .ser_out(so32), .ovf(ov32)
    );

    gcnt_top #(.CNT_W(8)) u_dut_w8 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .gate_n(gate_n), .load_n(load_n),
        .sclk_n(sclk_n), .src_sel(src_sel), .ext_sig(ext_sig), .ref_sig(ref_sig),
        .ser_out(so8), .ovf(ov8)
    );

    // Pin-level model: pins act three edges after they change.
    pins_t       h1 = PINS_IDLE, h2 = PINS_IDLE, h3 = PINS_IDLE;
    logic [31:0] mcnt = '0, msh = '0;
    logic [7:0]  mcnt8 = '0, msh8 = '0;
    logic        mov = 1'b0, mov8 = 1'b0;

    always @(posedge clk) begin
        pins_t now;
        logic  tick, srise;
        now = {clr_n, gate_n, load_n, sclk_n, src_sel, ext_sig, ref_sig};
        if (rst) begin
            h1 = PINS_IDLE; h2 = PINS_IDLE; h3 = PINS_IDLE;
            mcnt = 0; msh = 0; mcnt8 = 0; msh8 = 0; mov = 0; mov8 = 0;
        end else begin
            tick  = h2.sel ? (h2.refs && !h3.refs) : (h2.ext && !h3.ext);
            srise = h2.sclk_n && !h3.sclk_n;
            if (srise) begin
                if (!h2.load_n) begin msh = mcnt; msh8 = mcnt8; end
                else begin msh = msh << 1; msh8 = msh8 << 1; end
            end
            if (!h2.clr_n) begin
                mcnt = 0; mcnt8 = 0; mov = 0; mov8 = 0;
            end else if (!h2.gate_n && tick) begin
                if (mcnt == 32'hFFFF_FFFF) mov = 1;
                if (mcnt8 == 8'hFF) mov8 = 1;
                mcnt = mcnt + 1; mcnt8 = mcnt8 + 1;
            end
            h3 = h2; h2 = h1; h1 = now;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R9: per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !rst && !done) begin
            check(so32 == msh[31], "R9 ser_out w32", {31'b0, so32}, {31'b0, msh[31]});
            check(so8 == msh8[7], "R9 ser_out w8", {31'b0, so8}, {31'b0, msh8[7]});
            check(ov32 == mov, "R9 ovf w32", {31'b0, ov32}, {31'b0, mov});
            check(ov8 == mov8, "R9 ovf w8", {31'b0, ov8}, {31'b0, mov8});
        end
    end

    // Source stimulus: the reference toggles every cycle, the external every third.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            if (ref_run) ref_sig = ~ref_sig;
            k++;
            if (ext_run && (k % 3 == 0)) ext_sig = ~ext_sig;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_clear();
        clr_n = 1'b0; wait_n(4);
        clr_n = 1'b1; wait_n(4);
    endtask

    task automatic sclk_pulse();
        sclk_n = 1'b0; wait_n(4);
        sclk_n = 1'b1; wait_n(4);
    endtask

    task automatic read_out(output logic [31:0] v32, output logic [7:0] v8);
        v32 = '0; v8 = '0;
        load_n = 1'b0; wait_n(4);
        sclk_pulse();
        load_n = 1'b1; wait_n(4);
        for (int i = 0; i < 32; i++) begin
            v32 = {v32[30:0], so32};
            if (i < 8) v8 = {v8[6:0], so8};
            sclk_pulse();
        end
    endtask

    initial begin
        logic [31:0] r32, e32, prev32;
        logic [7:0]  r8, e8;
        wait_n(3);
        rst = 1'b0;
        started = 1'b1;
        wait_n(1);
        // R8: reset state
        check(so32 == 1'b0 && ov32 == 1'b0, "R8 reset outputs", {30'b0, so32, ov32}, 32'h0);
        check(so8 == 1'b0 && ov8 == 1'b0, "R8 reset outputs w8", {30'b0, so8, ov8}, 32'h0);

        // R1 / R5: count the reference for a fixed window
        src_sel = 1'b1; wait_n(4);
        host_clear();
        ref_run = 1'b1;
        gate_n = 1'b0; wait_n(100);
        gate_n = 1'b1; wait_n(6);
        e32 = mcnt; e8 = mcnt8;
        check(e32 > 40 && e32 < 60, "R1 reference edge count", e32, 32'd50);
        read_out(r32, r8);
        check(r32 == e32, "R5 readout w32", r32, e32);
        check(r8 == e8, "R5 readout w8", {24'b0, r8}, {24'b0, e8});

        // R6: after all bits are shifted, only zeros follow
        check(so32 == 1'b0, "R6 zero fill after 32 shifts", {31'b0, so32}, 32'h0);
        sclk_pulse(); sclk_pulse();
        check(so32 == 1'b0, "R6 extra shifts", {31'b0, so32}, 32'h0);

        // R2: gate closed, reference keeps running, value must not move
        prev32 = r32;
        wait_n(60);
        read_out(r32, r8);
        check(r32 == prev32, "R2 hold while gate closed", r32, prev32);

        // R4: select external with it stopped; reference edges are ignored
        src_sel = 1'b0; wait_n(4);
        host_clear();
        gate_n = 1'b0; wait_n(80);
        gate_n = 1'b1; wait_n(6);
        read_out(r32, r8);
        check(r32 == 32'd0, "R4 unselected source ignored", r32, 32'd0);
        ext_run = 1'b1;
        gate_n = 1'b0; wait_n(120);
        gate_n = 1'b1; wait_n(6);
        e32 = mcnt;
        read_out(r32, r8);
        check(r32 == e32 && e32 > 15 && e32 < 25, "R4 external count", r32, e32);
        ext_run = 1'b0;

        // R7: wrap on the narrow instance
        src_sel = 1'b1; wait_n(4);
        host_clear();
        gate_n = 1'b0; wait_n(600);
        gate_n = 1'b1; wait_n(6);
        e32 = mcnt; e8 = mcnt8;
        check(ov8 == 1'b1, "R7 overflow set on wrap", {31'b0, ov8}, 32'h1);
        check(ov32 == 1'b0, "R7 no overflow w32", {31'b0, ov32}, 32'h0);
        read_out(r32, r8);
        check(r8 == e32[7:0], "R7 wrapped value", {24'b0, r8}, {24'b0, e32[7:0]});
        check(r32 == e32, "R1 long window w32", r32, e32);
        wait_n(40);
        check(ov8 == 1'b1, "R7 overflow sticky", {31'b0, ov8}, 32'h1);

        // R9: clear takes effect on the third edge
        clr_n = 1'b0;
        wait_n(2);
        check(ov8 == 1'b1, "R9 before third edge", {31'b0, ov8}, 32'h1);
        wait_n(1);
        check(ov8 == 1'b0, "R9 third edge clears", {31'b0, ov8}, 32'h0);

        // R3: clear held low wins over an open gate
        gate_n = 1'b0; wait_n(50);
        gate_n = 1'b1; wait_n(6);
        clr_n = 1'b1; wait_n(4);
        read_out(r32, r8);
        check(r32 == 32'd0, "R3 clear priority", r32, 32'd0);
        check(ov8 == 1'b0, "R3 overflow cleared", {31'b0, ov8}, 32'h0);

        ref_run = 1'b0;
        wait_n(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule